// File: doc/BRIEF.md
# Message Time Tag Counter

This block keeps a 16-bit time stamp for a serial bus terminal. The counter runs freely, and the source of its advance pulse can be chosen. The first source is an internal prescaler that turns the system clock into a 1 µs base tick and then divides that tick by a power of two. The second is an external oscillator input, which passes through a synchroniser and an edge detector. The third is a single-cycle strobe from software, used for self-test. A fourth setting stops the counter.

The host can write a new value at any time and reads the live value from the `count` output. The protocol engine drives two event inputs. When a synchronize command arrives without data, it can clear the counter. When a synchronize command arrives with data, it can load the data word into the counter. Each of these actions has its own enable. At the start of every message, the engine pulses a capture input, and the block returns the value to be stored as that message's time-tag word. When the counter wraps from all-ones to zero, the block emits a one-cycle rollover pulse for the interrupt logic.

Top module: `msg_time_tag`

## Requirements
- R1: While reset is asserted, and just after it is released, `count` is 0 and `rollover` and `tagValid` are 0.
- R2: With `srcSel`=0 (internal), `count` advances once every 2^(resSel+1) µs, which is 2^(resSel+1)*CLK_MHZ clocks, for `resSel` 0..5. Codes 6 and 7 behave as code 5 (64 µs).
- R3: With `srcSel`=1 (external), `count` advances exactly once for each rising edge of `extTick`, a few clocks after the edge. A level held high or low causes no further steps.
- R4: With `srcSel`=2 (software), each cycle with `swStep` high adds one to `count`. With `srcSel`=3 (stopped), `count` holds its value, and `swStep` and `extTick` have no effect.
- R5: A cycle with `hostWr` high makes `count` equal to `hostData` in the next cycle.
- R6: A cycle with `syncNoData` and `syncClrEn` high clears `count` to 0 in the next cycle. With `syncClrEn` low, the same pulse leaves `count` unchanged.
- R7: A cycle with `syncWithData` and `syncLoadEn` high makes `count` equal to `syncData` in the next cycle.
- R8: Priority within one cycle is: sync clear, then sync load, then host write, then tick. At most one of these takes effect.
- R9: `rollover` is high for exactly the one cycle in which a tick has taken `count` from 0xFFFF to 0. A write or load that sets `count` to 0 raises no pulse.
- R10: A cycle with `msgStart` high makes `tagOut` equal, in the next cycle, to the `count` value present during the `msgStart` cycle, and `tagValid` is high for that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_MHZ MHz |
| rstN | input | 1 | Active-low synchronous reset |
| resSel | input | 3 | Resolution code, 2^(code+1) µs per step |
| srcSel | input | 2 | Advance source: 0 internal, 1 external, 2 software, 3 stopped |
| extTick | input | 1 | External oscillator, asynchronous |
| swStep | input | 1 | Software increment strobe |
| hostWr | input | 1 | Host write strobe |
| hostData | input | 16 | Host write value |
| syncClrEn | input | 1 | Enable clear on synchronize without data |
| syncLoadEn | input | 1 | Enable load on synchronize with data |
| syncNoData | input | 1 | Synchronize-without-data event pulse |
| syncWithData | input | 1 | Synchronize-with-data event pulse |
| syncData | input | 16 | Data word of the synchronize command |
| msgStart | input | 1 | Message start, captures the time tag |
| count | output | 16 | Live counter value |
| tagOut | output | 16 | Captured time-tag word |
| tagValid | output | 1 | tagOut updated this cycle |
| rollover | output | 1 | Wrap pulse from 0xFFFF to 0 |

## Verification
The assertions check several properties on every cycle. At most one counter action is granted per cycle. A clear, a host write, a capture and a wrap each reach the registers one cycle later with the right value. With no action granted, the counter holds still. The prescaler stays in range. Some behaviour only the bench scenarios can show: the exact tick spacing for each resolution code, the one-step-per-edge behaviour of the external input, which requests are ignored when an enable is low or the counter is stopped, and the time-tag values the scoreboard expects for each message start.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;

  localparam int TAG_W   = 16;
  localparam int MAX_EXP = 6;   // largest divide exponent: 2^6 us

  typedef enum logic [1:0] {
    SRC_INT  = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_SW   = 2'd2,
    SRC_STOP = 2'd3
  } tick_src_e;

  typedef struct packed {
    logic clr;   // synchronize clear
    logic ld;    // synchronize load
    logic wr;    // host write
    logic inc;   // tick
    logic cap;   // capture for a message
  } strobe_t;

endpackage

// File: rtl/tstamp_ctrl.sv
module tstamp_ctrl
  import tstamp_pkg::*;
#(
  parameter int CLK_MHZ     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] resSel,
  input  logic [1:0] srcSel,
  input  logic       extTick,
  input  logic       swStep,
  input  logic       hostWr,
  input  logic       syncClrEn,
  input  logic       syncLoadEn,
  input  logic       syncNoData,
  input  logic       syncWithData,
  input  logic       msgStart,
  output strobe_t    strb
);

  localparam int PRE_W = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1;
  localparam int DIV_W = MAX_EXP;
  localparam int EXT_W = SYNC_STAGES + 1;

  logic             usTick;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLimit;
  logic             intTick;
  logic [EXT_W-1:0] extPipe;
  logic             extRise;
  logic             tick;
  tick_src_e        src;

  // 1 us base tick
  generate
    if (CLK_MHZ == 1) begin : g_noPre
      assign usTick = 1'b1;
    end else begin : g_pre
      logic [PRE_W-1:0] preCnt;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          preCnt <= '0;
        end else if (preCnt == PRE_W'(CLK_MHZ - 1)) begin
          preCnt <= '0;
        end else begin
          preCnt <= preCnt + 1'b1;
        end
      end
      assign usTick = (preCnt == PRE_W'(CLK_MHZ - 1));

      AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
        int'(preCnt) < CLK_MHZ);  // R2
    end
  endgenerate

  // power-of-two divider; codes above the top exponent saturate
  always_comb begin
    int expVal;
    expVal = int'(resSel) + 1;
    if (expVal > MAX_EXP) expVal = MAX_EXP;
    divLimit = DIV_W'((1 << expVal) - 1);
  end

  assign intTick = usTick && (divCnt >= divLimit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (usTick) begin
      divCnt <= intTick ? '0 : divCnt + 1'b1;
    end
  end

  // external oscillator: synchroniser plus one stage for edge detect
  always_ff @(posedge clk) begin
    if (!rstN) begin
      extPipe <= '0;
    end else begin
      extPipe <= {extPipe[EXT_W-2:0], extTick};
    end
  end
  assign extRise = extPipe[EXT_W-2] & ~extPipe[EXT_W-1];

  assign src = tick_src_e'(srcSel);

  always_comb begin
    unique case (src)
      SRC_INT:  tick = intTick;
      SRC_EXT:  tick = extRise;
      SRC_SW:   tick = swStep;
      default:  tick = 1'b0;
    endcase
  end

  // priority: clear, load, host write, tick
  always_comb begin
    strb.clr = syncNoData & syncClrEn;
    strb.ld  = ~strb.clr & syncWithData & syncLoadEn;
    strb.wr  = ~strb.clr & ~strb.ld & hostWr;
    strb.inc = ~strb.clr & ~strb.ld & ~strb.wr & tick;
    strb.cap = msgStart;
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.clr, strb.ld, strb.wr, strb.inc}));  // R8

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (src == SRC_STOP) |-> !strb.inc);  // R4

endmodule

// File: rtl/tstamp_dp.sv
module tstamp_dp
  import tstamp_pkg::*;
#(
  parameter int W = TAG_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  strobe_t      strb,
  input  logic [W-1:0] hostData,
  input  logic [W-1:0] syncData,
  output logic [W-1:0] count,
  output logic [W-1:0] tagOut,
  output logic         tagValid,
  output logic         rollover
);

  logic [W-1:0] nextCount;
  logic         wrapNow;

  assign wrapNow = strb.inc & (&count);

  always_comb begin
    nextCount = count;
    if (strb.clr)      nextCount = '0;
    else if (strb.ld)  nextCount = syncData;
    else if (strb.wr)  nextCount = hostData;
    else if (strb.inc) nextCount = count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      rollover <= 1'b0;
      tagOut   <= '0;
      tagValid <= 1'b0;
    end else begin
      count    <= nextCount;
      rollover <= wrapNow;
      tagValid <= strb.cap;
      if (strb.cap) tagOut <= count;
    end
  end

  AST_WRAP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.inc && count == '1) |=> (rollover && count == '0));  // R9

  AST_NO_FALSE_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    !strb.inc |=> !rollover);  // R9

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.clr |=> count == '0);  // R6

  AST_HOST_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    strb.wr |=> count == $past(hostData));  // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.clr || strb.ld || strb.wr || strb.inc) |=> $stable(count));  // R4

  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strb.cap |=> (tagValid && tagOut == $past(count)));  // R10

endmodule

// File: rtl/msg_time_tag.sv
module msg_time_tag
  import tstamp_pkg::*;
#(
  parameter int CLK_MHZ = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        resSel,
  input  logic [1:0]        srcSel,
  input  logic              extTick,
  input  logic              swStep,
  input  logic              hostWr,
  input  logic [TAG_W-1:0]  hostData,
  input  logic              syncClrEn,
  input  logic              syncLoadEn,
  input  logic              syncNoData,
  input  logic              syncWithData,
  input  logic [TAG_W-1:0]  syncData,
  input  logic              msgStart,
  output logic [TAG_W-1:0]  count,
  output logic [TAG_W-1:0]  tagOut,
  output logic              tagValid,
  output logic              rollover
);

  strobe_t strb;

  tstamp_ctrl #(.CLK_MHZ(CLK_MHZ), .SYNC_STAGES(2)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .resSel       (resSel),
    .srcSel       (srcSel),
    .extTick      (extTick),
    .swStep       (swStep),
    .hostWr       (hostWr),
    .syncClrEn    (syncClrEn),
    .syncLoadEn   (syncLoadEn),
    .syncNoData   (syncNoData),
    .syncWithData (syncWithData),
    .msgStart     (msgStart),
    .strb         (strb)
  );

  tstamp_dp #(.W(TAG_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .hostData (hostData),
    .syncData (syncData),
    .count    (count),
    .tagOut   (tagOut),
    .tagValid (tagValid),
    .rollover (rollover)
  );

endmodule

// File: tb/sim_msg_time_tag.sv
module sim_msg_time_tag;

  localparam int MHZ = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  resSel = '0;
  logic [1:0]  srcSel = 2'd3;
  logic        extTick = 1'b0;
  logic        swStep = 1'b0;
  logic        hostWr = 1'b0;
  logic [15:0] hostData = '0;
  logic        syncClrEn = 1'b0;
  logic        syncLoadEn = 1'b0;
  logic        syncNoData = 1'b0;
  logic        syncWithData = 1'b0;
  logic [15:0] syncData = '0;
  logic        msgStart = 1'b0;
  logic [15:0] count;
  logic [15:0] tagOut;
  logic        tagValid;
  logic        rollover;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [15:0] expTag[$];

  always #5 clk = ~clk;

  msg_time_tag #(.CLK_MHZ(MHZ)) u0 (
    .clk(clk), .rstN(rstN), .resSel(resSel), .srcSel(srcSel),
    .extTick(extTick), .swStep(swStep), .hostWr(hostWr), .hostData(hostData),
    .syncClrEn(syncClrEn), .syncLoadEn(syncLoadEn), .syncNoData(syncNoData),
    .syncWithData(syncWithData), .syncData(syncData), .msgStart(msgStart),
    .count(count), .tagOut(tagOut), .tagValid(tagValid), .rollover(rollover)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver side of the scoreboard: pulse msgStart, push expected tag
  task automatic capture();
    expTag.push_back(count);
    msgStart = 1'b1;
    cyc(1);
    msgStart = 1'b0;
  endtask

  task automatic hostWrite(input logic [15:0] v);
    hostData = v; hostWr = 1'b1;
    cyc(1);
    hostWr = 1'b0;
  endtask

  task automatic step();
    swStep = 1'b1;
    cyc(1);
    swStep = 1'b0;
  endtask

  // monitor side: pop and compare on every tagValid
  always @(negedge clk) begin
    if (rstN && tagValid) begin
      if (expTag.size() == 0) begin
        check("R10 unexpected tag", 32'(tagValid), 32'd0);
      end else begin
        check("R10 tag value", 32'(tagOut), 32'(expTag.pop_front()));
      end
    end
  end

  task automatic measure(input logic [2:0] code, input int expCyc, input string req);
    logic [15:0] prev;
    int n;
    srcSel = 2'd0; resSel = code;
    for (int k = 0; k < 2; k++) begin
      prev = count; n = 0;
      do begin cyc(1); n++; end while (count == prev && n < 3000);
    end
    prev = count; n = 0;
    do begin cyc(1); n++; end while (count == prev && n < 3000);
    check(req, 32'(n), 32'(expCyc));
    check({req, " step"}, 32'(count), 32'(prev + 16'd1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    cyc(3);
    check("R1 count in reset", 32'(count), 32'd0);
    rstN = 1'b1;
    cyc(1);
    check("R1 count after reset", 32'(count), 32'd0);
    check("R1 rollover after reset", 32'(rollover), 32'd0);
    check("R1 tagValid after reset", 32'(tagValid), 32'd0);

    // R4 stopped: strobes ignored
    step();
    extTick = 1'b1; cyc(5); extTick = 1'b0; cyc(5);
    check("R4 stopped ignores strobes", 32'(count), 32'd0);

    // R4 software source
    srcSel = 2'd2;
    step(); step(); step();
    check("R4 software steps", 32'(count), 32'd3);

    // R5 host write
    hostWrite(16'hA5C3);
    check("R5 host write", 32'(count), 32'hA5C3);

    // R8 host write beats tick
    swStep = 1'b1; hostWrite(16'h0100); swStep = 1'b0;
    check("R8 write over tick", 32'(count), 32'h0100);

    // R6 clear disabled then enabled
    srcSel = 2'd3;
    syncNoData = 1'b1; cyc(1); syncNoData = 1'b0;
    check("R6 clear disabled", 32'(count), 32'h0100);
    syncClrEn = 1'b1;
    syncNoData = 1'b1; cyc(1); syncNoData = 1'b0;
    check("R6 clear enabled", 32'(count), 32'd0);

    // R7 load
    syncLoadEn = 1'b1; syncData = 16'h3C3C;
    syncWithData = 1'b1; cyc(1); syncWithData = 1'b0;
    check("R7 sync load", 32'(count), 32'h3C3C);

    // R8 load beats host write; clear beats load
    syncData = 16'h7777; syncWithData = 1'b1;
    hostWrite(16'h1111); syncWithData = 1'b0;
    check("R8 load over write", 32'(count), 32'h7777);
    syncNoData = 1'b1; syncWithData = 1'b1; syncData = 16'h2222;
    hostWrite(16'h3333);
    syncNoData = 1'b0; syncWithData = 1'b0;
    check("R8 clear over load and write", 32'(count), 32'd0);

    // R9 rollover via tick, none via write
    srcSel = 2'd2;
    hostWrite(16'hFFFE);
    step();
    check("R9 no pulse before wrap", 32'(rollover), 32'd0);
    step();
    check("R9 wrap value", 32'(count), 32'd0);
    check("R9 wrap pulse", 32'(rollover), 32'd1);
    cyc(1);
    check("R9 pulse one cycle", 32'(rollover), 32'd0);
    hostWrite(16'hFFFF);
    hostWrite(16'h0000);
    check("R9 no pulse on write", 32'(rollover), 32'd0);

    // R10 capture, including capture on a step cycle
    hostWrite(16'h1234);
    capture();
    check("R10 tagValid", 32'(tagValid), 32'd1);
    swStep = 1'b1; capture(); swStep = 1'b0;
    check("R10 count advanced", 32'(count), 32'h1235);
    cyc(1);
    check("R10 tagValid one cycle", 32'(tagValid), 32'd0);

    // R3 external source
    srcSel = 2'd1;
    v = count;
    extTick = 1'b1; cyc(6);
    check("R3 one step per edge", 32'(count), 32'(v + 16'd1));
    cyc(6);
    check("R3 held high no step", 32'(count), 32'(v + 16'd1));
    extTick = 1'b0; cyc(6);
    check("R3 falling no step", 32'(count), 32'(v + 16'd1));
    extTick = 1'b1; cyc(6); extTick = 1'b0; cyc(6);
    check("R3 second edge", 32'(count), 32'(v + 16'd2));
    swStep = 1'b1; cyc(3); swStep = 1'b0;
    check("R3 swStep ignored", 32'(count), 32'(v + 16'd2));

    // R2 internal resolutions
    measure(3'd0, 2 * MHZ, "R2 code0");
    measure(3'd3, 16 * MHZ, "R2 code3");
    measure(3'd5, 64 * MHZ, "R2 code5");
    measure(3'd7, 64 * MHZ, "R2 code7 saturates");

    srcSel = 2'd3;
    cyc(2);
    check("R10 scoreboard drained", 32'(expTag.size()), 32'd0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule